// File: doc/BRIEF.md
# Clear-on-Read Maskable Interrupt Controller

This block gathers single-cycle event pulses from a line interface into a set of category interrupt registers. Each category register has a mask register of the same width. An event whose mask bit is clear is latched as a pending bit. A masked event is dropped. An active-low interrupt request is pulled low while any pending bit has a clear mask bit. Otherwise the request is released to high impedance. The request comes out as an output enable plus a data value that is always low, so a tri-state pad can be inferred at the chip edge.

Software uses a simple strobe bus. It reads a category register to collect the pending bits, and that read clears that category. It writes the mask registers to choose which events may interrupt. A control register holds an acknowledge bit. Writing the opposite value into that bit clears every pending bit at once. An event that arrives in the same cycle as a clearing read or an acknowledge is kept pending.

Top module: `irqc_top`

## Requirements
- R1: After reset, every pending bit is 0 and every mask bit is 1 (all blocked). The acknowledge bit is 0, `irq_oe_o` is 0 and `irq_n_o` is 0. `irq_n_o` stays 0 at all times.
- R2: Address map: pending register k is at address k, and mask register k is at address NUM_CAT+k. The control register is at address 2*NUM_CAT, with the acknowledge flag in bit 0. Any other address reads 0. Read data is registered: it appears on `bus_rdata_o` in the cycle after the cycle in which `bus_rd_i` is sampled. It holds its value when no read is issued.
- R3: An event bit that is high at a clock edge while its mask bit is 0 sets the matching pending bit at that edge. The bit stays set until it is cleared. Events from several pulses accumulate by OR.
- R4: An event bit that arrives while its mask bit is 1 is not latched. A later unmasking does not bring it back.
- R5: `irq_oe_o` is 1 exactly when some pending bit has a mask bit of 0. Masking a pending bit releases the request, and unmasking it drives the request again.
- R6: Reading pending register k returns its value from before the read and clears only category k.
- R7: An unmasked event that arrives in the same cycle as a clearing read or an acknowledge is pending afterwards.
- R8: A control write whose bit 0 differs from the stored acknowledge flag clears all pending bits and stores the new flag. A write of the same value clears nothing.
- R9: Writes to pending-register addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CAT*CAT_W | Event pulses; category k occupies bits k*CAT_W and up |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | CAT_W | Write data |
| bus_rdata_o | output | CAT_W | Registered read data |
| irq_oe_o | output | 1 | Request pad enable; high pulls the line low |
| irq_n_o | output | 1 | Request pad data, constant low |

## Verification
Assertions check several properties on every cycle:
- a pending bit only rises after an unmasked event;
- a clearing read leaves nothing set except the events of that same cycle;
- an unmasked event is never lost;
- a toggling acknowledge releases the request unless a new event arrives with it;
- read data holds between reads.

The bench scenarios cover what needs a whole sequence to observe:
- the address map and the reset values;
- events that are dropped and not recovered when a mask is lifted later;
- request release and re-assertion caused by later mask writes;
- a clearing read of one category leaving the other categories untouched;
- an acknowledge write of the same value having no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_PEND = 2'd1,
      ACC_MASK = 2'd2,
      ACC_CTRL = 2'd3
   } acc_kind_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irqc_bus_dec.sv
module irqc_bus_dec
   import irqc_pkg::*;
#(
   parameter int NUM_CAT = 4,
   parameter int ADDR_W  = 4,
   localparam int IDX_W  = idx_width(NUM_CAT)
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               rd_i,
   input  logic               wr_i,
   output acc_kind_e          kind_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic [NUM_CAT-1:0] pend_rd_sel_o,
   output logic [NUM_CAT-1:0] mask_wr_sel_o,
   output logic               ctrl_wr_o
);
   localparam int CTRL_ADDR = 2 * NUM_CAT;

   always_comb begin
      int av;
      av     = int'(addr_i);
      kind_o = ACC_NONE;
      idx_o  = '0;
      if (av < NUM_CAT) begin
         kind_o = ACC_PEND;
         idx_o  = IDX_W'(av);
      end else if (av < CTRL_ADDR) begin
         kind_o = ACC_MASK;
         idx_o  = IDX_W'(av - NUM_CAT);
      end else if (av == CTRL_ADDR) begin
         kind_o = ACC_CTRL;
      end
   end

   for (genvar k = 0; k < NUM_CAT; k++) begin : g_sel
      assign pend_rd_sel_o[k] = rd_i && (kind_o == ACC_PEND) && (idx_o == IDX_W'(k));
      assign mask_wr_sel_o[k] = wr_i && (kind_o == ACC_MASK) && (idx_o == IDX_W'(k));
   end

   assign ctrl_wr_o = wr_i && (kind_o == ACC_CTRL);
endmodule

// File: rtl/irqc_cat_reg.sv
module irqc_cat_reg #(
   parameter int           W        = 8,
   parameter logic [W-1:0] MASK_RST = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] evt_i,
   input  logic         rd_clr_i,
   input  logic         ack_clr_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_wd_i,
   output logic [W-1:0] pend_o,
   output logic [W-1:0] mask_o,
   output logic         req_o
);
   logic [W-1:0] pend_q, mask_q, evt_live, pend_d;
   logic         clr;

   assign evt_live = evt_i & ~mask_q;
   assign clr      = rd_clr_i | ack_clr_i;
   assign pend_d   = (clr ? '0 : pend_q) | evt_live;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         mask_q <= MASK_RST;
      end else begin
         pend_q <= pend_d;
         if (mask_we_i) mask_q <= mask_wd_i;
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign req_o  = |(pend_q & ~mask_q);

   // R4
   masked_evt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pend_q & ~$past(pend_q) & ~$past(evt_i & ~mask_q)) == '0));

   // R6
   rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_clr_i |=> ((pend_q & ~$past(evt_i & ~mask_q)) == '0));

   // R7
   evt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(evt_i & ~mask_q)) |=> ((pend_q & $past(evt_i & ~mask_q)) == $past(evt_i & ~mask_q)));
endmodule

// File: rtl/irqc_ack.sv
module irqc_ack (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_i,
   input  logic bit_i,
   output logic ack_o,
   output logic clr_o
);
   logic ack_q;

   assign clr_o = wr_i && (bit_i != ack_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ack_q <= 1'b0;
      else if (wr_i) ack_q <= bit_i;
   end

   assign ack_o = ack_q;

   // R8
   ack_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_o |=> (ack_q != $past(ack_q)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NUM_CAT          = 4,
   parameter int CAT_W            = 8,
   parameter int ADDR_W           = 4,
   parameter bit MASK_RESET_BLOCK = 1'b1,
   parameter bit REQ_REG          = 1'b0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NUM_CAT*CAT_W-1:0] evt_i,
   input  logic [ADDR_W-1:0]        bus_addr_i,
   input  logic                     bus_rd_i,
   input  logic                     bus_wr_i,
   input  logic [CAT_W-1:0]         bus_wdata_i,
   output logic [CAT_W-1:0]         bus_rdata_o,
   output logic                     irq_oe_o,
   output logic                     irq_n_o
);
   localparam int IDX_W = idx_width(NUM_CAT);
   localparam logic [CAT_W-1:0] MASK_RST_VAL = MASK_RESET_BLOCK ? '1 : '0;

   if (NUM_CAT < 1 || NUM_CAT > 64) begin : g_bad_cat
      $error("irqc_top: NUM_CAT out of range");
   end
   if (CAT_W < 1) begin : g_bad_w
      $error("irqc_top: CAT_W must be positive");
   end
   if (ADDR_W > 16 || (2 * NUM_CAT) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irqc_top: ADDR_W cannot hold the register map");
   end

   acc_kind_e          kind;
   logic [IDX_W-1:0]   idx;
   logic [NUM_CAT-1:0] pend_rd_sel, mask_wr_sel, cat_req, evt_live;
   logic               ctrl_wr, ack_q, ack_clr;
   logic [CAT_W-1:0]   pend_w [NUM_CAT];
   logic [CAT_W-1:0]   mask_w [NUM_CAT];
   logic [CAT_W-1:0]   rd_next, rdata_q;

   irqc_bus_dec #(.NUM_CAT(NUM_CAT), .ADDR_W(ADDR_W)) u_dec (
      .addr_i        (bus_addr_i),
      .rd_i          (bus_rd_i),
      .wr_i          (bus_wr_i),
      .kind_o        (kind),
      .idx_o         (idx),
      .pend_rd_sel_o (pend_rd_sel),
      .mask_wr_sel_o (mask_wr_sel),
      .ctrl_wr_o     (ctrl_wr)
   );

   irqc_ack u_ack (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ctrl_wr),
      .bit_i  (bus_wdata_i[0]),
      .ack_o  (ack_q),
      .clr_o  (ack_clr)
   );

   for (genvar k = 0; k < NUM_CAT; k++) begin : g_cat
      irqc_cat_reg #(.W(CAT_W), .MASK_RST(MASK_RST_VAL)) u_cat (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .evt_i     (evt_i[k*CAT_W +: CAT_W]),
         .rd_clr_i  (pend_rd_sel[k]),
         .ack_clr_i (ack_clr),
         .mask_we_i (mask_wr_sel[k]),
         .mask_wd_i (bus_wdata_i),
         .pend_o    (pend_w[k]),
         .mask_o    (mask_w[k]),
         .req_o     (cat_req[k])
      );
      assign evt_live[k] = |(evt_i[k*CAT_W +: CAT_W] & ~mask_w[k]);
   end

   always_comb begin
      rd_next = '0;
      if (kind == ACC_CTRL) begin
         rd_next = CAT_W'(ack_q);
      end else begin
         for (int k = 0; k < NUM_CAT; k++) begin
            if (idx == IDX_W'(k)) begin
               if (kind == ACC_PEND)      rd_next = pend_w[k];
               else if (kind == ACC_MASK) rd_next = mask_w[k];
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_next;
   end

   assign bus_rdata_o = rdata_q;
   assign irq_n_o     = 1'b0;

   if (REQ_REG) begin : g_req_reg
      logic req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) req_q <= 1'b0;
         else         req_q <= |cat_req;
      end
      assign irq_oe_o = req_q;
   end else begin : g_req_comb
      assign irq_oe_o = |cat_req;

      // R8
      ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ack_clr && !(|evt_live)) |=> !irq_oe_o);
   end

   // R2
   rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
   localparam int NC = 4;
   localparam int W  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC*W-1:0] evt = '0;
   logic [3:0]    bus_addr = '0;
   logic          bus_rd = 1'b0, bus_wr = 1'b0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic          irq_oe, irq_n;

   irqc_top u_irqc_top (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
      .bus_addr_i(bus_addr), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .irq_oe_o(irq_oe), .irq_n_o(irq_n)
   );

   always #5 clk = ~clk;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } exp_t;
   exp_t sb_q[$];

   int n_chk = 0, n_fail = 0;
   logic [W-1:0] m_pend [NC];
   logic [W-1:0] m_mask [NC];
   logic         m_ack;
   logic         rd_seen = 1'b0;
   bit           done = 1'b0;

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when read data becomes valid
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin : mon
      exp_t e;
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R2: actual unexpected read data %h expected none", bus_rdata);
         end else begin
            e = sb_q.pop_front();
            check(bus_rdata, e.exp, e.tag);
         end
      end
   end

   function automatic void model_evt(input logic [NC*W-1:0] v);
      for (int k = 0; k < NC; k++) m_pend[k] |= v[k*W +: W] & ~m_mask[k];
   endfunction

   function automatic logic [W-1:0] model_read(input int a);
      if (a < NC)          return m_pend[a];
      else if (a < 2*NC)   return m_mask[a-NC];
      else if (a == 2*NC)  return W'(m_ack);
      return '0;
   endfunction

   task automatic pulse(input logic [NC*W-1:0] v);
      evt = v;
      @(negedge clk);
      evt = '0;
      model_evt(v);
   endtask

   task automatic bus_write(input int a, input logic [W-1:0] d, input logic [NC*W-1:0] v);
      bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1; evt = v;
      @(negedge clk);
      bus_wr = 1'b0; evt = '0;
      if (a >= NC && a < 2*NC) begin
         model_evt(v);
         m_mask[a-NC] = d;
      end else begin
         if (a == 2*NC) begin
            if (d[0] != m_ack) for (int k = 0; k < NC; k++) m_pend[k] = '0;
            m_ack = d[0];
         end
         model_evt(v);
      end
   endtask

   task automatic bus_read(input int a, input logic [NC*W-1:0] v, input string tag);
      exp_t e;
      e.exp = model_read(a);
      e.tag = tag;
      sb_q.push_back(e);
      bus_addr = 4'(a); bus_rd = 1'b1; evt = v;
      @(negedge clk);
      bus_rd = 1'b0; evt = '0;
      if (a < NC) m_pend[a] = '0;
      model_evt(v);
   endtask

   task automatic chk_irq(input string tag);
      logic want = 1'b0;
      for (int k = 0; k < NC; k++) if ((m_pend[k] & ~m_mask[k]) != '0) want = 1'b1;
      check(W'(irq_oe), W'(want), tag);
      check(W'(irq_n), '0, "R5 pad data");
   endtask

   initial begin
      for (int k = 0; k < NC; k++) begin m_pend[k] = '0; m_mask[k] = '1; end
      m_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_irq("R1 reset request");
      for (int a = 0; a <= 2*NC; a++) bus_read(a, '0, "R1 reset register");
      // R2 unmapped address reads zero
      bus_read(9, '0, "R2 unmapped");
      bus_read(15, '0, "R2 unmapped top");
      // R4 masked events dropped
      pulse('1);
      chk_irq("R4 masked no request");
      bus_write(NC+0, 8'hF7, '0);
      bus_read(0, '0, "R4 dropped after unmask");
      // R3 latch and accumulate
      pulse(32'h0000_0028);
      chk_irq("R3 request after event");
      pulse(32'h0000_0001);
      bus_read(0, '0, "R3 latched bit");
      chk_irq("R6 release after read");
      bus_read(0, '0, "R6 cleared");
      // R6 per-category clear
      for (int k = 0; k < NC; k++) bus_write(NC+k, 8'h00, '0);
      pulse(32'h8100_4200);
      pulse(32'h0100_0400);
      bus_read(1, '0, "R6 read cat1");
      chk_irq("R6 others still pending");
      bus_read(3, '0, "R6 read cat3");
      chk_irq("R6 all clear");
      bus_read(1, '0, "R6 cat1 stays clear");
      // R7 event in same cycle as read
      pulse(32'h0002_0000);
      bus_read(2, 32'h0001_0000, "R7 read with event");
      chk_irq("R7 request kept");
      bus_read(2, '0, "R7 event kept");
      // R5 mask after pending releases, unmask re-drives
      pulse(32'h0000_0010);
      bus_write(NC+0, 8'h10, '0);
      chk_irq("R5 masked pending released");
      bus_write(NC+0, 8'h00, '0);
      chk_irq("R5 unmasked pending drives");
      // R9 write to pending address ignored
      bus_write(0, 8'hFF, '0);
      bus_write(1, 8'hFF, '0);
      bus_read(1, '0, "R9 pending write ignored");
      // R8 acknowledge toggle
      pulse(32'h1122_3344);
      bus_write(2*NC, 8'h01, '0);
      chk_irq("R8 toggle clears");
      bus_read(2*NC, '0, "R8 flag stored");
      for (int a = 0; a < NC; a++) bus_read(a, '0, "R8 all cleared");
      pulse(32'h0000_0300);
      bus_write(2*NC, 8'h01, '0);
      chk_irq("R8 same value keeps");
      bus_read(1, '0, "R8 same value no clear");
      pulse(32'h0000_0005);
      bus_write(2*NC, 8'h00, 32'h0400_0000);
      chk_irq("R7 event with ack");
      bus_read(0, '0, "R8 cleared by toggle back");
      bus_read(3, '0, "R7 event kept through ack");
      bus_read(2*NC, '0, "R8 flag back to zero");
      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R2: actual %0d reads unanswered expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule